// File: doc/BRIEF.md
# Reloading External Event Down-Counter

This block is one timer channel that counts edges on an external event input. Software writes a reload value, picks which edges count and whether a short-glitch filter is used, then fires a start trigger. The trigger copies the reload value into the count register. Each accepted edge after that takes one off the count. An accepted edge that arrives while the count is already zero puts the reload value back into the count and gives a one-clock interrupt pulse. A channel programmed with reload value R therefore interrupts once every R+1 edges, and it keeps doing so until it is stopped.

The event input first goes through a synchroniser. It can then pass through a level filter, and after that an edge detector. The count register can be read at any time. The reload value can be rewritten while the channel runs, and the new value is used at the next wrap. The edge and filter settings are frozen while the channel runs. The stop trigger freezes the count where it is. A unit-level enable input holds the whole channel, registers included, in its reset state and blocks register writes.

Top module: `evtcnt_channel`

## Requirements
- R1: Writing control (address 2) with bit0 = 1 starts the channel, and control bit2 (running) then reads 1. Control bits 0 and 1 are triggers and always read 0. Writing bit1 = 1 stops the channel, and stop takes priority over a start in the same write.
- R2: A start loads the reload register (address 0) into the count register (address 1) on the same clock edge.
- R3: While running, each accepted edge on a nonzero count lowers the count by one.
- R4: While running, an accepted edge on a count of zero loads the reload value into the count. With reload R, the channel wraps after R+1 edges.
- R5: The irq output is a one-clock pulse issued on the clock edge that performs the wrap of R4, and at no other time.
- R6: After a stop, the count keeps its value and later edges change neither the count nor irq.
- R7: Mode register (address 3) bits[1:0] select the counted edges: 00 falling, 01 rising, 10 both, 11 none. With the filter off, a full input pulse gives 1, 1, 2 and 0 counts respectively.
- R8: A reload write while running leaves the current count alone and takes effect at the next wrap.
- R9: Writes to the mode register are ignored while the channel runs.
- R10: Mode bit2 enables the filter. With the filter on, an input level that lasts only one clock is not counted. With the filter off, that same level is counted.
- R11: While unit_en is low, all registers read 0, irq is low, and register writes are ignored.
- R12: An edge that is detected on the same clock as a start trigger is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_en | input | 1 | Unit enable; low clears the channel and blocks writes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W | Read data (combinational) |
| evt_in | input | 1 | Asynchronous event input |
| irq | output | 1 | One-clock interrupt pulse on wrap |

## Verification
The bench builds the channel with its default parameters: a 16-bit count, a two-stage synchroniser and a two-sample filter. It keeps reload values between 0 and 3, so that several wraps happen within a few input pulses. On that configuration it sweeps every edge mode, both filter settings and each small reload value. The final count and the number of interrupts are predicted from the edge count modulo R+1. Separate sequences aim a one-clock glitch at the filter, place an edge exactly on the start clock, rewrite the reload value mid-run, and drop unit_en.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
   typedef enum logic [1:0] {
      EDGE_FALL = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_BOTH = 2'b10,
      EDGE_NONE = 2'b11
   } edge_mode_e;

   localparam int ADDR_W = 2;
   localparam logic [ADDR_W-1:0] A_RELOAD = 2'd0;
   localparam logic [ADDR_W-1:0] A_COUNT  = 2'd1;
   localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;
   localparam logic [ADDR_W-1:0] A_MODE   = 2'd3;

   localparam int CTL_START = 0;
   localparam int CTL_STOP  = 1;
   localparam int CTL_RUN   = 2;
   localparam int MOD_FILT  = 2;
endpackage

// File: rtl/evtcnt_insync.sv
module evtcnt_insync #(
   parameter int STAGES     = 2,
   parameter int FILT_LEN   = 2,
   parameter bit HAS_FILTER = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic din,
   input  logic filt_en,
   output logic dout
);
   logic [STAGES-1:0] sh;
   logic              sync_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sh <= '0;
      else if (clr) sh <= '0;
      else          sh <= {sh[STAGES-2:0], din};
   end
   assign sync_lvl = sh[STAGES-1];

   generate
      if (HAS_FILTER) begin : g_filt
         logic [FILT_LEN-1:0] hist;
         logic                flt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist <= '0;
               flt  <= 1'b0;
            end else if (clr) begin
               hist <= '0;
               flt  <= 1'b0;
            end else begin
               hist <= {hist[FILT_LEN-2:0], sync_lvl};
               if (&hist)       flt <= 1'b1;
               else if (~|hist) flt <= 1'b0;
            end
         end
         assign dout = filt_en ? flt : sync_lvl;
      end else begin : g_nofilt
         assign dout = sync_lvl;
      end
   endgenerate
endmodule

// File: rtl/evtcnt_edgedet.sv
module evtcnt_edgedet
   import evtcnt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       lvl,
   input  edge_mode_e mode,
   output logic       pulse
);
   logic prev;
   logic rise;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prev <= 1'b0;
      else if (clr) prev <= 1'b0;
      else          prev <= lvl;
   end

   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;

   always_comb begin
      unique case (mode)
         EDGE_FALL: pulse = fall;
         EDGE_RISE: pulse = rise;
         EDGE_BOTH: pulse = rise | fall;
         default:   pulse = 1'b0;
      endcase
   end
endmodule

// File: rtl/evtcnt_core.sv
module evtcnt_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         start,
   input  logic         stop,
   input  logic         edge_i,
   input  logic [W-1:0] reload,
   output logic [W-1:0] cnt,
   output logic         running,
   output logic         irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
         irq     <= 1'b0;
      end else if (clr) begin
         cnt     <= '0;
         running <= 1'b0;
         irq     <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (stop) begin
            running <= 1'b0;
         end else if (start) begin
            running <= 1'b1;
            cnt     <= reload;
         end else if (running && edge_i) begin
            if (cnt == '0) begin
               cnt <= reload;
               irq <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/evtcnt_channel.sv
module evtcnt_channel
   import evtcnt_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int SYNC_STG   = 2,
   parameter int FILT_LEN   = 2,
   parameter bit HAS_FILTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unit_en,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [1:0]        rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   input  logic              evt_in,
   output logic              irq
);
   generate
      if (CNT_W < 4)    begin : g_bad_w   $error("CNT_W must be at least 4"); end
      if (SYNC_STG < 2) begin : g_bad_s   $error("SYNC_STG must be at least 2"); end
      if (FILT_LEN < 2) begin : g_bad_f   $error("FILT_LEN must be at least 2"); end
   endgenerate

   logic             clr;
   logic             wr_ok;
   logic             start_p;
   logic             stop_p;
   logic             edge_p;
   logic             lvl;
   logic             running;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload_q;
   edge_mode_e       mode_q;
   logic             filt_q;

   assign clr     = ~unit_en;
   assign wr_ok   = wr_en & unit_en;
   assign start_p = wr_ok && (wr_addr == A_CTRL) && wr_data[CTL_START];
   assign stop_p  = wr_ok && (wr_addr == A_CTRL) && wr_data[CTL_STOP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         mode_q   <= EDGE_FALL;
         filt_q   <= 1'b0;
      end else if (clr) begin
         reload_q <= '0;
         mode_q   <= EDGE_FALL;
         filt_q   <= 1'b0;
      end else if (wr_ok) begin
         if (wr_addr == A_RELOAD) reload_q <= wr_data;
         if (wr_addr == A_MODE && !running) begin
            mode_q <= edge_mode_e'(wr_data[1:0]);
            filt_q <= wr_data[MOD_FILT];
         end
      end
   end

   evtcnt_insync #(
      .STAGES(SYNC_STG), .FILT_LEN(FILT_LEN), .HAS_FILTER(HAS_FILTER)
   ) u_sync (
      .clk(clk), .rst_n(rst_n), .clr(clr), .din(evt_in),
      .filt_en(filt_q), .dout(lvl)
   );

   evtcnt_edgedet u_edge (
      .clk(clk), .rst_n(rst_n), .clr(clr), .lvl(lvl),
      .mode(mode_q), .pulse(edge_p)
   );

   evtcnt_core #(.W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .clr(clr), .start(start_p), .stop(stop_p),
      .edge_i(edge_p), .reload(reload_q), .cnt(cnt_q),
      .running(running), .irq(irq)
   );

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         A_RELOAD: rd_data = reload_q;
         A_COUNT:  rd_data = cnt_q;
         A_CTRL:   rd_data[CTL_RUN] = running;
         default: begin
            rd_data[1:0]      = mode_q;
            rd_data[MOD_FILT] = filt_q;
         end
      endcase
   end
endmodule

// File: rtl/evtcnt_channel_chk.sv
module evtcnt_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             unit_en,
   input logic             irq,
   input logic             running,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] reload,
   input logic             edge_p,
   input logic             start_p,
   input logic             stop_p
);
   p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n || !unit_en)
      start_p && !stop_p |=> running && cnt == $past(reload));

   p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n || !unit_en)
      running && edge_p && !start_p && !stop_p && cnt != '0 |=> cnt == $past(cnt) - 1'b1);

   p_wrap_reload_r4: assert property (@(posedge clk) disable iff (!rst_n || !unit_en)
      running && edge_p && !start_p && !stop_p && cnt == '0 |=> irq && cnt == $past(reload));

   p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n || !unit_en)
      irq |-> $past(running && edge_p && cnt == '0));

   p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n || !unit_en)
      !running && !start_p |=> $stable(cnt) && !irq);

   p_unit_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !unit_en |=> cnt == '0 && !running && !irq && reload == '0);
endmodule

bind evtcnt_channel evtcnt_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .irq(irq),
   .running(running), .cnt(cnt_q), .reload(reload_q),
   .edge_p(edge_p), .start_p(start_p), .stop_p(stop_p)
);

// File: tb/test_evtcnt_channel.sv
`timescale 1ns/1ps
module test_evtcnt_channel;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         unit_en = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [1:0]   rd_addr = '0;
   logic [W-1:0] rd_data;
   logic         evt_in = 1'b0;
   logic         irq;

   int checks = 0;
   int fails = 0;
   int irq_seen = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   evtcnt_channel i_evtcnt_channel (
      .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .evt_in(evt_in), .irq(irq)
   );

   always @(posedge clk) if (irq) irq_seen <= irq_seen + 1;

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      rd_addr = a;
      #1;
      v = int'(rd_data);
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         evt_in = 1'b1; repeat (8) @(negedge clk);
         evt_in = 1'b0; repeat (8) @(negedge clk);
      end
   endtask

   task automatic glitch();
      @(negedge clk); evt_in = 1'b1;
      @(negedge clk); evt_in = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int v, v2, per, exp_cnt, exp_irq, nedge;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      unit_en = 1'b1;
      @(negedge clk);

      // Reset state
      rd(2'd0, v); chk("reset R11 reload", v, 0);
      rd(2'd1, v); chk("reset R11 count", v, 0);
      rd(2'd2, v); chk("reset R1 ctrl", v, 0);
      chk("reset R5 irq", int'(irq), 0);

      // R1 / R2: start sets running, triggers read 0, count loaded
      wr(2'd3, 1);
      wr(2'd0, 7);
      wr(2'd2, 1);
      rd(2'd2, v); chk("R1 running bit, triggers 0", v, 4);
      rd(2'd1, v); chk("R2 count loaded at start", v, 7);
      wr(2'd2, 3);
      rd(2'd2, v); chk("R1 stop wins over start", v, 0);

      // Sweep: mode x filter x reload (R3 R4 R5 R7)
      for (int m = 0; m < 4; m++) begin
         for (int f = 0; f < 2; f++) begin
            for (int r = 0; r < 4; r++) begin
               wr(2'd2, 2);
               wr(2'd3, (f << 2) | m);
               wr(2'd0, r);
               repeat (6) @(negedge clk);
               wr(2'd2, 1);
               rd(2'd1, v); chk("R2 sweep start load", v, r);
               irq_seen = 0;
               pulses(5);
               nedge = (m == 2) ? 10 : ((m == 3) ? 0 : 5);
               per = r + 1;
               exp_cnt = r - (nedge % per);
               exp_irq = nedge / per;
               rd(2'd1, v); chk("R3 R7 sweep count", v, exp_cnt);
               chk("R4 R5 sweep irq pulses", irq_seen, exp_irq);
            end
         end
      end

      // R8: reload rewrite mid-run used at next wrap
      wr(2'd2, 2);
      wr(2'd3, 1);
      wr(2'd0, 2);
      wr(2'd2, 1);
      wr(2'd0, 3);
      rd(2'd1, v); chk("R8 count untouched by reload write", v, 2);
      irq_seen = 0;
      pulses(3);
      rd(2'd1, v); chk("R8 new reload after wrap", v, 3);
      chk("R8 R5 one irq", irq_seen, 1);

      // R9: mode locked while running
      wr(2'd3, 6);
      rd(2'd3, v); chk("R9 mode write ignored while running", v, 1);

      // R6: stop holds count
      pulses(1);
      rd(2'd1, v);
      wr(2'd2, 2);
      irq_seen = 0;
      pulses(4);
      rd(2'd1, v2); chk("R6 count held after stop", v2, v);
      chk("R6 no irq after stop", irq_seen, 0);
      chk("R6 count value", v, 2);

      // R10: glitch filtered vs unfiltered
      wr(2'd3, 5);
      wr(2'd0, 5);
      repeat (6) @(negedge clk);
      wr(2'd2, 1);
      glitch();
      rd(2'd1, v); chk("R10 glitch rejected with filter", v, 5);
      wr(2'd2, 2);
      wr(2'd3, 1);
      repeat (6) @(negedge clk);
      wr(2'd2, 1);
      glitch();
      rd(2'd1, v); chk("R10 glitch counted without filter", v, 4);

      // R12: edge on the start clock is ignored
      wr(2'd2, 2);
      wr(2'd0, 6);
      repeat (6) @(negedge clk);
      evt_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = W'(1);
      @(negedge clk);
      wr_en = 1'b0;
      repeat (6) @(negedge clk);
      evt_in = 1'b0;
      repeat (8) @(negedge clk);
      rd(2'd1, v); chk("R12 coincident edge not counted", v, 6);
      pulses(1);
      rd(2'd1, v); chk("R12 later edge counted", v, 5);

      // R11: unit disable clears and blocks writes
      unit_en = 1'b0;
      repeat (2) @(negedge clk);
      rd(2'd0, v); chk("R11 reload cleared", v, 0);
      rd(2'd1, v); chk("R11 count cleared", v, 0);
      rd(2'd2, v); chk("R11 stopped", v, 0);
      wr(2'd0, 9);
      wr(2'd2, 1);
      irq_seen = 0;
      pulses(2);
      unit_en = 1'b1;
      @(negedge clk);
      rd(2'd0, v); chk("R11 write ignored while disabled", v, 0);
      rd(2'd2, v); chk("R11 start ignored while disabled", v, 0);
      chk("R11 no irq while disabled", irq_seen, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule